// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block turns one requested access into a short series of accesses on a direct register port, so that a requester can reach a wide secondary register space through a single register. Bit 63 of the incoming 64-bit address selects the kind of access. When it is clear, the block makes one plain direct access to the register given by the address's low 31 bits. When it is set, the block writes a packed command word to that same register. It then reads the register back until the hardware reports that the command has completed, reports an error, or the poll limit is used up.

The requester hands over an address, a read/write flag and 16 bits of write data while the block is idle. The block returns a two-bit status, a three-bit error code and 16 bits of read data. It holds that result until the requester acknowledges it. On the downstream side it drives a level request with a register address, a write flag and a 64-bit word. It expects a one-cycle response strobe carrying a fail flag and a 64-bit read word.

Top module: `ind_seq_top`

## Requirements
- R1: After reset the block is idle: req_ready is 1, res_valid is 0 and dp_req is 0.
- R2: If address bit 63 is clear, exactly one direct access is made to register address[30:0]. A write sends the 16-bit write data zero-extended to 64 bits. A successful read returns dp_rdata[15:0] with status OK (0).
- R3: For an indirect read, the first access is a write to register address[30:0]. Its word has bit 63 set, bits [51:32] equal to address[51:32], and every other bit zero.
- R4: For an indirect write, the first access is a write to register address[30:0]. Its word has bits [51:32] from the address, bits [15:0] from the write data, and every other bit zero.
- R5: After the command word, every later access is a read of the same register. A poll reply with bit 31 set and bits [30:28] equal to zero ends the access with status OK (0). For a read, the reply's bits [15:0] are returned.
- R6: A poll reply with bit 31 set and a nonzero field in bits [30:28] ends the access at once with status indirect-error (1), and res_code carries that field. With any other status, res_code is 0.
- R7: At most 10 polls are made. If none of them has bit 31 set, the status is timeout (2) after exactly 10 polls. Bits [30:28] of a poll reply with bit 31 clear have no effect.
- R8: A response with dp_fail set ends the sequence at once with status port-failure (3), and no further access is made.
- R9: A read that does not end with status OK returns 16'hFFFF. A write always returns 0 as read data.
- R10: From the moment an access is accepted until the result is acknowledged, req_ready is 0 and new requests are ignored. res_valid, res_status, res_code and res_rdata stay constant until res_ack.
- R11: While dp_req is high and no response has arrived, dp_addr, dp_write and dp_wdata do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Block is idle and accepts an access |
| req_addr | input | 64 | Access address; bit 63 selects indirect |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| res_valid | output | 1 | Result available |
| res_ack | input | 1 | Requester takes the result |
| res_status | output | 2 | 0 OK, 1 indirect-error, 2 timeout, 3 port-failure |
| res_code | output | 3 | Error field of the failing poll reply |
| res_rdata | output | 16 | Read data |
| dp_req | output | 1 | Direct-port request (level) |
| dp_write | output | 1 | Direct-port write flag |
| dp_addr | output | 31 | Direct-port register address |
| dp_wdata | output | 64 | Direct-port write word |
| dp_resp | input | 1 | Direct-port response strobe (one cycle) |
| dp_fail | input | 1 | Direct-port access failed, valid with dp_resp |
| dp_rdata | input | 64 | Direct-port read word, valid with dp_resp |

## Verification
The assertions rely on the direct port raising dp_resp only while dp_req is high, for a single cycle per request, with dp_fail meaningful only alongside it. They also rely on the requester leaving res_ack low until res_valid is seen. The bench's port model answers only requests it has captured, after a random latency of zero to two extra cycles. It pulses the response for exactly one cycle. The requester acknowledges only after it has observed the result. Random traffic keeps the poll-reply fields arbitrary outside the completion and error bits. It also pushes garbage request offers while a result is held, and these are still legal inputs that must be ignored.

// File: rtl/ind_seq_pkg.sv
package ind_seq_pkg;

    localparam int ADDR_W      = 64;
    localparam int WORD_W      = 64;
    localparam int REG_W       = 31;
    localparam int HALF_W      = 16;
    localparam int CODE_W      = 3;
    localparam int IND_SEL_BIT = 63;
    localparam int RD_FLAG_BIT = 63;
    localparam int FWD_LO      = 32;
    localparam int FWD_HI      = 51;
    localparam int DONE_BIT    = 31;
    localparam int CODE_HI     = 30;
    localparam int CODE_LO     = 28;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_IND_ERR   = 2'd1,
        ST_TIMEOUT   = 2'd2,
        ST_PORT_FAIL = 2'd3
    } ind_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIRECT,
        S_CMD,
        S_POLL,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        V_PENDING,
        V_GOOD,
        V_BAD
    } poll_verdict_e;

    typedef struct packed {
        logic              indirect;
        logic              write;
        logic [REG_W-1:0]  reg_addr;
        logic [WORD_W-1:0] word;
    } packed_req_t;

    function automatic logic [WORD_W-1:0] span_mask(input int hi, input int lo);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/ind_cmd_pack.sv
module ind_cmd_pack
    import ind_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [HALF_W-1:0] wdata,
    output packed_req_t       pkt
);
    localparam logic [WORD_W-1:0] FWD_MASK = span_mask(FWD_HI, FWD_LO);

    logic [WORD_W-1:0] fwd_bits;
    logic [WORD_W-1:0] data_ext;

    always_comb begin
        fwd_bits     = addr & FWD_MASK;
        data_ext     = {{(WORD_W-HALF_W){1'b0}}, wdata};
        pkt.indirect = addr[IND_SEL_BIT];
        pkt.write    = write;
        pkt.reg_addr = addr[REG_W-1:0];
        if (addr[IND_SEL_BIT]) begin
            if (write) begin
                pkt.word = fwd_bits | data_ext;
            end else begin
                pkt.word = fwd_bits;
                pkt.word[RD_FLAG_BIT] = 1'b1;
            end
        end else begin
            pkt.word = write ? data_ext : '0;
        end
    end
endmodule

// File: rtl/ind_resp_eval.sv
module ind_resp_eval
    import ind_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output poll_verdict_e     verdict,
    output logic [CODE_W-1:0] code,
    output logic [HALF_W-1:0] data
);
    logic done;

    always_comb begin
        done = word[DONE_BIT];
        code = word[CODE_HI:CODE_LO];
        data = word[HALF_W-1:0];
        if (!done) begin
            verdict = V_PENDING;
        end else if (code == '0) begin
            verdict = V_GOOD;
        end else begin
            verdict = V_BAD;
        end
    end
endmodule

// File: rtl/ind_poll_ctr.sv
module ind_poll_ctr #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(LIMIT - 1));

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT))
        else $error("R7: poll counter beyond limit");
endmodule

// File: rtl/ind_seq_top.sv
module ind_seq_top
    import ind_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              res_valid,
    input  logic              res_ack,
    output logic [1:0]        res_status,
    output logic [2:0]        res_code,
    output logic [15:0]       res_rdata,
    output logic              dp_req,
    output logic              dp_write,
    output logic [30:0]       dp_addr,
    output logic [63:0]       dp_wdata,
    input  logic              dp_resp,
    input  logic              dp_fail,
    input  logic [63:0]       dp_rdata
);
    localparam logic [HALF_W-1:0] FILL = '1;

    seq_state_e        state;
    packed_req_t       pkt_in;
    packed_req_t       pkt_q;
    ind_status_e       status_q;
    logic [CODE_W-1:0] code_q;
    logic [HALF_W-1:0] rdata_q;

    poll_verdict_e     verdict;
    logic [CODE_W-1:0] rsp_code;
    logic [HALF_W-1:0] rsp_data;
    logic              poll_last;
    logic              poll_step;
    logic              took;

    ind_cmd_pack u_pack (
        .addr  (req_addr),
        .write (req_write),
        .wdata (req_wdata),
        .pkt   (pkt_in)
    );

    ind_resp_eval u_eval (
        .word    (dp_rdata),
        .verdict (verdict),
        .code    (rsp_code),
        .data    (rsp_data)
    );

    ind_poll_ctr #(.LIMIT(POLL_LIMIT)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == S_CMD),
        .step (poll_step),
        .last (poll_last)
    );

    assign took      = dp_req && dp_resp;
    assign poll_step = took && !dp_fail && (state == S_POLL) && (verdict == V_PENDING);

    assign req_ready  = (state == S_IDLE);
    assign res_valid  = (state == S_DONE);
    assign res_status = status_q;
    assign res_code   = code_q;
    assign res_rdata  = rdata_q;

    assign dp_req   = (state == S_DIRECT) || (state == S_CMD) || (state == S_POLL);
    assign dp_addr  = pkt_q.reg_addr;
    assign dp_write = (state == S_CMD) || ((state == S_DIRECT) && pkt_q.write);
    assign dp_wdata = (state == S_POLL) ? '0 : pkt_q.word;

    function automatic logic [HALF_W-1:0] pick_data(input ind_status_e st,
                                                    input logic wr,
                                                    input logic [HALF_W-1:0] d);
        if (wr) return '0;
        if (st != ST_OK) return FILL;
        return d;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pkt_q    <= '0;
            status_q <= ST_OK;
            code_q   <= '0;
            rdata_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        pkt_q <= pkt_in;
                        state <= pkt_in.indirect ? S_CMD : S_DIRECT;
                    end
                end
                S_DIRECT: begin
                    if (took) begin
                        state    <= S_DONE;
                        code_q   <= '0;
                        status_q <= dp_fail ? ST_PORT_FAIL : ST_OK;
                        rdata_q  <= pick_data(dp_fail ? ST_PORT_FAIL : ST_OK,
                                              pkt_q.write, dp_rdata[HALF_W-1:0]);
                    end
                end
                S_CMD: begin
                    if (took) begin
                        if (dp_fail) begin
                            state    <= S_DONE;
                            status_q <= ST_PORT_FAIL;
                            code_q   <= '0;
                            rdata_q  <= pick_data(ST_PORT_FAIL, pkt_q.write, '0);
                        end else begin
                            state <= S_POLL;
                        end
                    end
                end
                S_POLL: begin
                    if (took) begin
                        if (dp_fail) begin
                            state    <= S_DONE;
                            status_q <= ST_PORT_FAIL;
                            code_q   <= '0;
                            rdata_q  <= pick_data(ST_PORT_FAIL, pkt_q.write, '0);
                        end else if (verdict == V_GOOD) begin
                            state    <= S_DONE;
                            status_q <= ST_OK;
                            code_q   <= '0;
                            rdata_q  <= pick_data(ST_OK, pkt_q.write, rsp_data);
                        end else if (verdict == V_BAD) begin
                            state    <= S_DONE;
                            status_q <= ST_IND_ERR;
                            code_q   <= rsp_code;
                            rdata_q  <= pick_data(ST_IND_ERR, pkt_q.write, '0);
                        end else if (poll_last) begin
                            state    <= S_DONE;
                            status_q <= ST_TIMEOUT;
                            code_q   <= '0;
                            rdata_q  <= pick_data(ST_TIMEOUT, pkt_q.write, '0);
                        end
                    end
                end
                S_DONE: begin
                    if (res_ack) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R10: result held steady until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ack) |=> (res_valid && $stable(res_status)
                                     && $stable(res_code) && $stable(res_rdata)))
        else $error("R10: result changed before acknowledge");

    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("R10: still ready after accept");

    // R11: downstream request stable while outstanding
    a_r11_stable: assert property (@(posedge clk) disable iff (rst)
        (dp_req && !dp_resp) |=> (dp_req && $stable(dp_addr)
                                  && $stable(dp_write) && $stable(dp_wdata)))
        else $error("R11: downstream request changed while outstanding");

    // R8: a port failure ends the sequence
    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        (dp_req && dp_resp && dp_fail) |=> (!dp_req && res_valid
                                           && res_status == ST_PORT_FAIL))
        else $error("R8: sequence continued after port failure");

    // R9: failed reads return all ones
    a_r9_fill: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status != ST_OK && !pkt_q.write) |-> (res_rdata == FILL))
        else $error("R9: failed read data not all ones");

    // R6: error code only meaningful with indirect-error
    a_r6_code: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((res_status == ST_IND_ERR) == (res_code != '0)))
        else $error("R6: code and status disagree");

    // R1: no downstream traffic while idle
    a_r1_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!dp_req && !res_valid))
        else $error("R1: activity while idle");
endmodule

// File: tb/ind_seq_top_tb_top.sv
module ind_seq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        req_write;
    logic [15:0] req_wdata;
    logic        res_valid;
    logic        res_ack;
    logic [1:0]  res_status;
    logic [2:0]  res_code;
    logic [15:0] res_rdata;
    logic        dp_req;
    logic        dp_write;
    logic [30:0] dp_addr;
    logic [63:0] dp_wdata;
    logic        dp_resp;
    logic        dp_fail;
    logic [63:0] dp_rdata;

    always #2 clk = ~clk;

    ind_seq_top dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata),
        .res_valid(res_valid), .res_ack(res_ack), .res_status(res_status),
        .res_code(res_code), .res_rdata(res_rdata),
        .dp_req(dp_req), .dp_write(dp_write), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_resp(dp_resp), .dp_fail(dp_fail), .dp_rdata(dp_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // scenario for the port model
    bit          sc_ind;
    int          sc_fail_at;
    int          sc_done_at;
    logic [2:0]  sc_err;
    int          acc_n;
    logic [63:0] last_word;
    logic [30:0] log_addr [16];
    logic        log_wr   [16];
    logic [63:0] log_wd   [16];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // direct-port model
    initial begin
        dp_resp  = 1'b0;
        dp_fail  = 1'b0;
        dp_rdata = '0;
        forever begin
            @(negedge clk);
            if (dp_req && !rst) begin
                automatic int k = acc_n;
                automatic int lat = $urandom_range(0, 2);
                automatic logic [63:0] w;
                automatic bit cpl;
                if (k < 16) begin
                    log_addr[k] = dp_addr;
                    log_wr[k]   = dp_write;
                    log_wd[k]   = dp_wdata;
                end
                acc_n++;
                repeat (lat) @(negedge clk);
                if (!sc_ind || k == 0) begin
                    w = {$urandom, $urandom};
                end else begin
                    cpl = (k >= sc_done_at);
                    w = {$urandom, cpl, (cpl ? sc_err : 3'($urandom)),
                         12'($urandom), 16'($urandom)};
                end
                last_word = w;
                dp_rdata  = w;
                dp_fail   = (k == sc_fail_at);
                dp_resp   = 1'b1;
                @(negedge clk);
                dp_resp = 1'b0;
                dp_fail = 1'b0;
            end
        end
    end

    // expected outcome from the requirements
    task automatic predict(input bit ind, input int fail_at, input int done_at,
                           input logic [2:0] err, output int n, output logic [1:0] st,
                           output logic [2:0] code);
        code = 3'd0;
        if (!ind) begin
            n  = 1;
            st = (fail_at == 0) ? 2'd3 : 2'd0;
            return;
        end
        if (fail_at == 0) begin
            n = 1; st = 2'd3; return;
        end
        for (int p = 1; p <= 10; p++) begin
            if (fail_at == p) begin
                n = p + 1; st = 2'd3; return;
            end
            if (p >= done_at) begin
                n = p + 1;
                if (err != 0) begin
                    st = 2'd1; code = err;
                end else begin
                    st = 2'd0;
                end
                return;
            end
        end
        n = 11; st = 2'd2;
    endtask

    task automatic run_txn(input logic [63:0] addr, input bit wr, input logic [15:0] wd,
                           input int fail_at, input int done_at, input logic [2:0] err,
                           input int hold);
        int n_exp;
        logic [1:0] st_exp;
        logic [2:0] code_exp;
        logic [15:0] rd_exp;
        logic [63:0] w_exp;
        int waitc;
        int n_seen;
        sc_ind     = addr[63];
        sc_fail_at = fail_at;
        sc_done_at = done_at;
        sc_err     = err;
        acc_n      = 0;
        predict(addr[63], fail_at, done_at, err, n_exp, st_exp, code_exp);

        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = addr;
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (!res_valid && waitc < 200) begin
            @(negedge clk);
            waitc++;
        end
        chk(res_valid == 1'b1, "R5 result appears", 64'(res_valid), 64'd1);

        if (wr) rd_exp = 16'h0;
        else if (st_exp != 2'd0) rd_exp = 16'hFFFF;
        else rd_exp = last_word[15:0];

        chk(res_status == st_exp, "R5/R6/R7/R8 status", 64'(res_status), 64'(st_exp));
        chk(res_code == code_exp, "R6 code", 64'(res_code), 64'(code_exp));
        chk(res_rdata == rd_exp, "R9 read data", 64'(res_rdata), 64'(rd_exp));
        chk(acc_n == n_exp, "R7/R8 access count", 64'(acc_n), 64'(n_exp));

        if (addr[63]) begin
            if (wr) w_exp = (addr & 64'h000F_FFFF_0000_0000) | 64'(wd);
            else    w_exp = (addr & 64'h000F_FFFF_0000_0000) | 64'h8000_0000_0000_0000;
            chk(log_wr[0] == 1'b1 && log_addr[0] == addr[30:0] && log_wd[0] == w_exp,
                wr ? "R4 command word" : "R3 command word", log_wd[0], w_exp);
            for (int i = 1; i < n_exp && i < 16; i++) begin
                chk(log_wr[i] == 1'b0 && log_addr[i] == addr[30:0], "R5 poll is read of same register",
                    {32'(log_wr[i]), 1'b0, log_addr[i]}, {32'd0, 1'b0, addr[30:0]});
            end
        end else begin
            chk(log_wr[0] == wr && log_addr[0] == addr[30:0], "R2 direct access target",
                {32'(log_wr[0]), 1'b0, log_addr[0]}, {32'(wr), 1'b0, addr[30:0]});
            if (wr) chk(log_wd[0] == 64'(wd), "R2 direct write data", log_wd[0], 64'(wd));
        end

        // garbage offers while holding the result
        n_seen = acc_n;
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1;
            req_addr  = {$urandom, $urandom};
            req_write = 1'($urandom);
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (hold > 0) begin
            chk(res_valid == 1'b1 && req_ready == 1'b0 && acc_n == n_seen,
                "R10 result held and offers ignored",
                {res_valid, req_ready, 62'(acc_n)}, {1'b1, 1'b0, 62'(n_seen)});
            chk(res_status == st_exp && res_rdata == rd_exp, "R10 result unchanged",
                {res_status, res_rdata}, {st_exp, rd_exp});
        end
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
        chk(req_ready == 1'b1 && res_valid == 1'b0, "R10 idle after acknowledge",
            {req_ready, res_valid}, 2'b10);
    endtask

    initial begin
        void'($urandom(32'd12345));
        rst = 1'b1; req_valid = 0; req_addr = '0; req_write = 0; req_wdata = '0;
        res_ack = 0; acc_n = 0; sc_ind = 0; sc_fail_at = 99; sc_done_at = 1; sc_err = 0;
        last_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(res_valid == 1'b0, "R1 no result after reset", 64'(res_valid), 64'd0);
        chk(dp_req == 1'b0, "R1 no request after reset", 64'(dp_req), 64'd0);

        // directed corners
        run_txn(64'h7FFF_FFFF_1234_5678, 0, 16'h0, 99, 1, 0, 2);     // R2 direct read
        run_txn(64'h0000_0000_0ABC_DEF0, 1, 16'hBEEF, 99, 1, 0, 0);  // R2 direct write
        run_txn(64'h0000_0000_0000_0042, 0, 16'h0, 0, 1, 0, 1);      // R8 direct fail
        run_txn(64'h8123_4567_89AB_CDEF, 0, 16'h0, 99, 1, 0, 0);     // R3/R5 ok first poll
        run_txn(64'hFFFF_FFFF_FFFF_FFFF, 1, 16'hA5C3, 99, 10, 0, 0); // R4/R7 ok last poll
        run_txn(64'h8000_0000_0000_0011, 0, 16'h0, 99, 11, 0, 3);    // R7 timeout
        run_txn(64'h8000_0000_0000_0012, 1, 16'h1111, 99, 50, 0, 0); // R7 timeout write
        run_txn(64'h800A_BCDE_0000_0013, 0, 16'h0, 99, 3, 3'd7, 2);  // R6 error code
        run_txn(64'h8000_0000_0000_0014, 1, 16'h2222, 0, 1, 0, 0);   // R8 command fail
        run_txn(64'h8000_0000_0000_0015, 0, 16'h0, 5, 9, 0, 0);      // R8 poll fail
        run_txn(64'h8000_0000_0000_0016, 1, 16'h3333, 99, 4, 3'd1, 0); // R6 write err

        for (int t = 0; t < 60; t++) begin
            automatic logic [63:0] a = {$urandom, $urandom};
            automatic int fa = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 11)) : 99;
            automatic int da = $urandom_range(1, 12);
            automatic logic [2:0] e = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
            run_txn(a, 1'($urandom), 16'($urandom), fa, da, e, $urandom_range(0, 3));
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule